// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command receiver of a serial NOR flash. It watches the chip-select, serial clock and serial input pins in the system clock domain, using SPI mode 0 with one data bit per SCLK edge. It collects the opcode, the address bytes and any write payload, classifies the opcode, and decides at chip-select release whether a modifying command may run. Only single-bit SPI transfers are handled.

Commands that modify state are "framed" commands: write enable, write disable, status write, page program, sector erase, block erase, chip erase, deep power-down, suspend and resume. Each one is handed to the core as a one-cycle execute pulse carrying the opcode and the address. It is handed over only when the transaction ended cleanly on a byte boundary and was long enough. Otherwise a one-cycle reject pulse is raised instead. Page-program and status-write payload bytes stream to the core as they complete. A partial trailing byte is never streamed and never affects the write-enable latch.

Read-type commands (status read, release, read and fast read) stream response bytes from the core out on the serial output, MSB first. The write stream has a valid strobe and no ready, because the serial clock cannot be stalled, so the core must take every beat. The response stream is valid/ready. The block raises ready while it is in a data-out phase and its one-byte holding slot is empty. A byte transfers on any clock cycle in which valid and ready are both high. If the slot is still empty when the next output byte starts, 0xFF is sent. The serial clock and chip select must already be synchronous to `clk`. Each SCLK level must last at least 3 clock cycles, and chip select must rise no sooner than 2 cycles after the last SCLK edge.

Top module: `flash_cmd_frontend`

## Requirements
- R1: The first 8 bits after chip select falls form the opcode, shifted MSB first and sampled on rising SCLK edges. An executed command reports that opcode on `exec_op_o`.
- R2: Opcodes 03h, 0Bh, 02h, 20h and D8h carry an address after the opcode, MSB first. The address is 3 bytes, zero-extended to 32 bits, when `four_byte_i` is low at the opcode. It is 4 bytes when `four_byte_i` is high at the opcode.
- R3: A framed command executes if, when chip select rises, the SCLK rising-edge count is a multiple of 8 and the byte count reaches its minimum. The framed commands are 06h, 04h, 01h, 02h, 20h, D8h, C7h, B9h, 75h and 7Ah. The minimum is the opcode plus its address for 20h/D8h, plus one data byte for 02h, 2 bytes for 01h, and 1 byte for the rest. `exec_o` then pulses for one cycle, in the cycle after the first clock edge that samples chip select high.
- R4: A framed command that misses R3's condition pulses `rej_o` at the same time instead. `exec_o` and `rej_o` are never high together.
- R5: Read-type commands (05h, ABh, 03h, 0Bh) never pulse `exec_o` or `rej_o`, however many bits have been clocked when chip select rises.
- R6: An unknown opcode, or a chip-select release before 8 bits, produces no pulse and leaves `wel_o` unchanged.
- R7: `wel_o` resets to 0. It is set by an executed 06h and cleared by an executed 04h, 01h, 02h, 20h, D8h or C7h. A rejected command leaves it unchanged.
- R8: Each complete payload byte of 02h (after its address) or 01h (after its opcode) gives one `wr_vld_o` pulse with the byte on `wr_data_o`. A partial byte gives none.
- R9: After the last header bit of a read-type command, `rsp_ready_o` rises. The header is the opcode for 05h and ABh, the opcode and address for 03h, and the opcode, address and one dummy byte for 0Bh. From the next falling SCLK edge on, the accepted byte appears on `so_o`, MSB first, one bit per falling edge, with a new byte every 8 edges.
- R10: If no response byte is held when an output byte begins, that byte is 0xFF.
- R11: Suspend (75h) and resume (7Ah) are framed commands without an address.
- R12: All shift and framing state clears while chip select is high, so a transaction aborted at any bit does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, 0 outside a data-out phase |
| four_byte_i | input | 1 | Selects 4-byte addressing when high |
| rsp_data_i | input | 8 | Response byte from the core |
| rsp_valid_i | input | 1 | Response byte is valid |
| rsp_ready_o | output | 1 | Response holding slot can take a byte |
| wr_vld_o | output | 1 | One-cycle strobe for a payload byte |
| wr_data_o | output | 8 | Payload byte |
| exec_o | output | 1 | One-cycle execute strobe |
| exec_op_o | output | 8 | Opcode of the executed command |
| exec_addr_o | output | 32 | Address of the executed command |
| rej_o | output | 1 | One-cycle reject strobe |
| wel_o | output | 1 | Write-enable latch |

## Verification
A corrupted bit or byte counter shows up at chip-select release, in the very next cycle: a well-framed command is rejected, or a broken one executes. A stale opcode register shows up in the same cycle, as the wrong value on `exec_op_o`. An address register shifted the wrong number of times gives a wrong `exec_addr_o` on the same execute pulse. A data-out phase armed at the wrong header byte shifts the response out one or more bytes off, or shifts 0xFF. A bad payload-byte decision shows up as a missing or extra `wr_vld_o`, 2 cycles after the rising SCLK edge that completes the byte. A latch update taken on a reject flips `wel_o` in the cycle of the `rej_o` pulse.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 32;
  typedef logic [CNT_W-1:0] bcnt_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE    = 8'hD8;
  localparam logic [7:0] OP_CE    = 8'hC7;
  localparam logic [7:0] OP_DPD   = 8'hB9;
  localparam logic [7:0] OP_REL   = 8'hAB;
  localparam logic [7:0] OP_SUS   = 8'h75;
  localparam logic [7:0] OP_RES   = 8'h7A;

  typedef enum logic [2:0] {
    CL_NONE, CL_READ, CL_BARE, CL_ADDR, CL_PROG, CL_WREG
  } cmd_class_e;

  function automatic cmd_class_e class_of(logic [7:0] op);
    case (op)
      OP_RDSR, OP_REL, OP_READ, OP_FREAD:              return CL_READ;
      OP_WREN, OP_WRDI, OP_CE, OP_DPD, OP_SUS, OP_RES: return CL_BARE;
      OP_SE, OP_BE:                                    return CL_ADDR;
      OP_PP:                                           return CL_PROG;
      OP_WRSR:                                         return CL_WREG;
      default:                                         return CL_NONE;
    endcase
  endfunction

  function automatic logic has_addr(logic [7:0] op);
    return (op == OP_READ) || (op == OP_FREAD) || (op == OP_PP) ||
           (op == OP_SE) || (op == OP_BE);
  endfunction

  function automatic bcnt_t addr_len(logic a4);
    return a4 ? bcnt_t'(4) : bcnt_t'(3);
  endfunction

  // bytes up to and including the last header byte (opcode, address, dummy)
  function automatic bcnt_t hdr_bytes(logic [7:0] op, logic a4);
    if (op == OP_FREAD)   return bcnt_t'(addr_len(a4) + bcnt_t'(2));
    else if (has_addr(op)) return bcnt_t'(addr_len(a4) + bcnt_t'(1));
    else                  return bcnt_t'(1);
  endfunction

  function automatic bcnt_t min_bytes(logic [7:0] op, logic a4);
    if (op == OP_PP)        return bcnt_t'(hdr_bytes(op, a4) + bcnt_t'(1));
    else if (op == OP_WRSR) return bcnt_t'(2);
    else                    return hdr_bytes(op, a4);
  endfunction
endpackage

// File: rtl/flash_cmd_rx.sv
module flash_cmd_rx
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       si_i,
  output logic       fall_o,
  output logic       cs_rise_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output bcnt_t      byte_idx_o,
  output logic [2:0] bit_cnt_o,
  output bcnt_t      byte_cnt_o
);
  logic       sclk_q, cs_q, rise;
  logic [6:0] sh_q;

  assign rise      = sclk_i & ~sclk_q & ~cs_n_i;
  assign fall_o    = ~sclk_i & sclk_q & ~cs_n_i;
  assign cs_rise_o = cs_n_i & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      sh_q       <= '0;
      bit_cnt_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else begin
      sclk_q     <= sclk_i;
      cs_q       <= cs_n_i;
      byte_vld_o <= 1'b0;
      if (cs_n_i) begin
        sh_q       <= '0;
        bit_cnt_o  <= '0;
        byte_cnt_o <= '0;
      end else if (rise) begin
        sh_q      <= {sh_q[5:0], si_i};
        bit_cnt_o <= bit_cnt_o + 3'd1;
        if (bit_cnt_o == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, si_i};
          byte_idx_o <= byte_cnt_o;
          if (byte_cnt_o != '1) byte_cnt_o <= byte_cnt_o + bcnt_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              cs_rise_i,
  input  logic              four_byte_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  bcnt_t             byte_idx_i,
  input  logic [2:0]        bit_cnt_i,
  input  bcnt_t             byte_cnt_i,
  output logic              exec_o,
  output logic              rej_o,
  output logic [7:0]        exec_op_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic              wr_vld_o,
  output logic [7:0]        wr_data_o,
  output logic              wel_o,
  output logic              rd_on_o
);
  logic [7:0]        op_q;
  logic              a4_q;
  logic [ADDR_W-1:0] addr_q;
  cmd_class_e        cls_q, cls_cur;
  logic [7:0]        op_cur;
  logic              a4_cur, framed, frame_ok, first;
  bcnt_t             hdr_cur;

  assign first    = (byte_idx_i == '0);
  assign op_cur   = first ? byte_i : op_q;
  assign a4_cur   = first ? four_byte_i : a4_q;
  assign cls_q    = class_of(op_q);
  assign cls_cur  = class_of(op_cur);
  assign hdr_cur  = hdr_bytes(op_cur, a4_cur);
  assign framed   = (cls_q != CL_NONE) && (cls_q != CL_READ);
  assign frame_ok = (bit_cnt_i == 3'd0) && (byte_cnt_i >= min_bytes(op_q, a4_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_o      <= 1'b0;
      rej_o       <= 1'b0;
      exec_op_o   <= '0;
      exec_addr_o <= '0;
      wr_vld_o    <= 1'b0;
      wr_data_o   <= '0;
      wel_o       <= 1'b0;
      rd_on_o     <= 1'b0;
      op_q        <= '0;
      a4_q        <= 1'b0;
      addr_q      <= '0;
    end else begin
      exec_o   <= 1'b0;
      rej_o    <= 1'b0;
      wr_vld_o <= 1'b0;
      if (cs_rise_i && (byte_cnt_i != '0) && framed) begin
        if (frame_ok) begin
          exec_o      <= 1'b1;
          exec_op_o   <= op_q;
          exec_addr_o <= addr_q;
          if (op_q == OP_WREN) wel_o <= 1'b1;
          else if (op_q == OP_WRDI || op_q == OP_WRSR || op_q == OP_PP ||
                   op_q == OP_SE || op_q == OP_BE || op_q == OP_CE)
            wel_o <= 1'b0;
        end else begin
          rej_o <= 1'b1;
        end
      end
      if (cs_n_i) begin
        op_q    <= '0;
        a4_q    <= 1'b0;
        addr_q  <= '0;
        rd_on_o <= 1'b0;
      end else if (byte_vld_i) begin
        if (first) begin
          op_q <= byte_i;
          a4_q <= four_byte_i;
        end else if (has_addr(op_q) && byte_idx_i <= addr_len(a4_q)) begin
          addr_q <= {addr_q[ADDR_W-9:0], byte_i};
        end
        if (!first && (cls_q == CL_PROG || cls_q == CL_WREG) &&
            byte_idx_i >= hdr_bytes(op_q, a4_q)) begin
          wr_vld_o  <= 1'b1;
          wr_data_o <= byte_i;
        end
        if (cls_cur == CL_READ && bcnt_t'(byte_idx_i + bcnt_t'(1)) == hdr_cur)
          rd_on_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_tx.sv
module flash_cmd_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       rd_on_i,
  input  logic [7:0] rsp_data_i,
  input  logic       rsp_valid_i,
  output logic       rsp_ready_o,
  output logic       so_o
);
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  logic [7:0] hold_q, sh_q;
  logic       full_q, take, load;
  logic [2:0] obit_q;

  assign rsp_ready_o = rd_on_i & ~full_q;
  assign take        = rsp_valid_i & rsp_ready_o;
  assign load        = fall_i & (obit_q == 3'd0);
  assign so_o        = rd_on_i & sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      obit_q <= '0;
    end else if (!rd_on_i) begin
      sh_q   <= '0;
      full_q <= 1'b0;
      obit_q <= '0;
    end else begin
      if (fall_i) obit_q <= obit_q + 3'd1;
      if (load) begin
        sh_q   <= full_q ? hold_q : (take ? rsp_data_i : IDLE_BYTE);
        full_q <= 1'b0;
      end else begin
        if (fall_i) sh_q <= {sh_q[6:0], 1'b0};
        if (take) begin
          hold_q <= rsp_data_i;
          full_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  output logic              so_o,
  input  logic              four_byte_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  output logic              wr_vld_o,
  output logic [7:0]        wr_data_o,
  output logic              exec_o,
  output logic [7:0]        exec_op_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  output logic              rej_o,
  output logic              wel_o
);
  logic       fall, cs_rise, byte_vld, rd_on;
  logic [7:0] byte_v;
  bcnt_t      byte_idx, byte_cnt;
  logic [2:0] bit_cnt;

  flash_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .si_i(si_i),
    .fall_o(fall), .cs_rise_o(cs_rise), .byte_vld_o(byte_vld), .byte_o(byte_v),
    .byte_idx_o(byte_idx), .bit_cnt_o(bit_cnt), .byte_cnt_o(byte_cnt)
  );

  flash_cmd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cs_rise_i(cs_rise),
    .four_byte_i(four_byte_i), .byte_vld_i(byte_vld), .byte_i(byte_v),
    .byte_idx_i(byte_idx), .bit_cnt_i(bit_cnt), .byte_cnt_i(byte_cnt),
    .exec_o(exec_o), .rej_o(rej_o), .exec_op_o(exec_op_o),
    .exec_addr_o(exec_addr_o), .wr_vld_o(wr_vld_o), .wr_data_o(wr_data_o),
    .wel_o(wel_o), .rd_on_o(rd_on)
  );

  flash_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .rd_on_i(rd_on),
    .rsp_data_i(rsp_data_i), .rsp_valid_i(rsp_valid_i),
    .rsp_ready_o(rsp_ready_o), .so_o(so_o)
  );
endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_i,
  input logic       rsp_ready_o,
  input logic       wr_vld_o,
  input logic       exec_o,
  input logic [7:0] exec_op_o,
  input logic       rej_o,
  input logic       wel_o
);
  assert_exec_rej_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_o && rej_o));

  assert_verdict_at_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o || rej_o) |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

  assert_wel_set_by_wren_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> (exec_o && exec_op_o == 8'h06));

  assert_wel_kept_on_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rej_o |-> $stable(wel_o));

  assert_wr_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |-> !$past(cs_n_i, 2));

  assert_wr_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |=> !wr_vld_o);

  assert_ready_inside_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready_o |-> !$past(cs_n_i));
endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .rsp_ready_o(rsp_ready_o),
  .wr_vld_o(wr_vld_o), .exec_o(exec_o), .exec_op_o(exec_op_o),
  .rej_o(rej_o), .wel_o(wel_o)
);

// File: tb/flash_cmd_frontend_tb.sv
`timescale 1ns/1ps
module flash_cmd_frontend_tb;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, si = 1'b0, a4 = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic rsp_valid = 1'b0;
  logic so, rsp_ready, wr_vld, exec_s, rej_s, wel;
  logic [7:0] wr_data, exec_op;
  logic [31:0] exec_addr;

  always #2.5 clk = ~clk;

  flash_cmd_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .si_i(si), .so_o(so),
    .four_byte_i(a4), .rsp_data_i(rsp_data), .rsp_valid_i(rsp_valid),
    .rsp_ready_o(rsp_ready), .wr_vld_o(wr_vld), .wr_data_o(wr_data),
    .exec_o(exec_s), .exec_op_o(exec_op), .exec_addr_o(exec_addr),
    .rej_o(rej_s), .wel_o(wel)
  );

  int errs = 0, checks = 0, n_exec = 0, n_rej = 0, n_wr = 0;
  logic [7:0] last_op = 8'h00, last_wr = 8'h00;
  logic [31:0] last_addr = 32'h0;
  logic saw_ready = 1'b0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (exec_s) begin n_exec++; last_op = exec_op; last_addr = exec_addr; end
    if (rej_s) n_rej++;
    if (wr_vld) begin n_wr++; last_wr = wr_data; end
    if (rsp_ready) saw_ready = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    si = b; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      tick(2);
      r[i] = so;
      pulse_bit(1'b0);
    end
  endtask

  task automatic open_x;  cs_n = 1'b0; tick(4); endtask
  task automatic close_x; tick(4); cs_n = 1'b1; tick(6); endtask

  typedef struct packed {
    logic [7:0] op; logic [3:0] nb; logic [2:0] xb; logic a4; logic ex; logic rj;
  } vec_t;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'h06, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h04, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h06, 4'd0, 3'd3, 1'b0, 1'b0, 1'b1},
    '{8'hC7, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'hC7, 4'd1, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'hB9, 4'd0, 3'd5, 1'b0, 1'b0, 1'b1},
    '{8'h20, 4'd3, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h20, 4'd2, 3'd0, 1'b0, 1'b0, 1'b1},
    '{8'hD8, 4'd3, 3'd1, 1'b0, 1'b0, 1'b1},
    '{8'hD8, 4'd4, 3'd0, 1'b1, 1'b1, 1'b0},
    '{8'h02, 4'd4, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h02, 4'd3, 3'd0, 1'b0, 1'b0, 1'b1},
    '{8'h02, 4'd5, 3'd4, 1'b0, 1'b0, 1'b1},
    '{8'h01, 4'd1, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h75, 4'd0, 3'd0, 1'b0, 1'b1, 1'b0},
    '{8'h7A, 4'd0, 3'd2, 1'b0, 1'b0, 1'b1},
    '{8'h03, 4'd3, 3'd5, 1'b0, 1'b0, 1'b0},
    '{8'h05, 4'd0, 3'd3, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 4'd2, 3'd0, 1'b0, 1'b0, 1'b0},
    '{8'h20, 4'd3, 3'd0, 1'b1, 1'b0, 1'b1}
  };

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog (R12): actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int e0, r0, w0;
    logic [7:0] rb;
    tick(5);
    // R7 R3: reset state of all outputs
    check("R7 reset outputs", {31'd0, exec_s | rej_s | wel | rsp_ready | so | wr_vld}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    rsp_valid = 1'b1; rsp_data = 8'h5A;

    // table walk: R1 R3 R4 R5 R6 R11
    for (int k = 0; k < NV; k++) begin
      a4 = VEC[k].a4; e0 = n_exec; r0 = n_rej;
      open_x();
      send_byte(VEC[k].op);
      for (int j = 0; j < int'(VEC[k].nb); j++) send_byte(8'h10 + 8'(j));
      for (int j = 0; j < int'(VEC[k].xb); j++) pulse_bit(1'b1);
      close_x();
      check($sformatf("R3/R4/R5/R6/R11 exec count vec %0d", k), n_exec - e0, 32'(VEC[k].ex));
      check($sformatf("R4/R5 reject count vec %0d", k), n_rej - r0, 32'(VEC[k].rj));
      if (VEC[k].ex) check($sformatf("R1 opcode vec %0d", k), {24'd0, last_op}, {24'd0, VEC[k].op});
    end

    // R2: 3-byte address, zero extended
    a4 = 1'b0; open_x(); send_byte(8'h20); send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); close_x();
    check("R2 three-byte address", last_addr, 32'h0012_3456);
    // R2: 4-byte address
    a4 = 1'b1; open_x(); send_byte(8'hD8); send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3); send_byte(8'hD4); close_x();
    check("R2 four-byte address", last_addr, 32'hA1B2_C3D4);
    a4 = 1'b0;

    // R7: write enable sets the latch
    open_x(); send_byte(8'h06); close_x();
    check("R7 latch set by 06h", {31'd0, wel}, 32'd1);

    // R8 R7: program with a partial trailing byte is rejected, latch kept
    w0 = n_wr; r0 = n_rej;
    open_x(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h01); send_byte(8'h02);
    send_byte(8'hAA); send_byte(8'hBB); pulse_bit(1'b1); pulse_bit(1'b0); pulse_bit(1'b1); close_x();
    check("R8 full payload bytes streamed", n_wr - w0, 32'd2);
    check("R8 last payload byte", {24'd0, last_wr}, 32'hBB);
    check("R4 partial program rejected", n_rej - r0, 32'd1);
    check("R7 latch kept after reject", {31'd0, wel}, 32'd1);

    // R8 R7: clean program executes and clears the latch
    w0 = n_wr;
    open_x(); send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h10); send_byte(8'hCC); close_x();
    check("R8 one payload byte", n_wr - w0, 32'd1);
    check("R7 latch cleared by program", {31'd0, wel}, 32'd0);

    // R9: status read returns held byte twice, MSB first
    rsp_valid = 1'b1; rsp_data = 8'hA5; saw_ready = 1'b0; e0 = n_exec; r0 = n_rej;
    open_x(); send_byte(8'h05); recv_byte(rb);
    check("R9 first response byte", {24'd0, rb}, 32'hA5);
    recv_byte(rb);
    check("R9 second response byte", {24'd0, rb}, 32'hA5);
    close_x();
    check("R9 ready raised", {31'd0, saw_ready}, 32'd1);
    check("R5 no verdict on read", (n_exec - e0) + (n_rej - r0), 32'd0);

    // R9: fast read skips one dummy byte
    rsp_data = 8'h3C;
    open_x(); send_byte(8'h0B); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'hFF);
    recv_byte(rb); close_x();
    check("R9 fast read after dummy", {24'd0, rb}, 32'h3C);

    // R10: nothing held gives 0xFF
    rsp_valid = 1'b0;
    open_x(); send_byte(8'h03); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    recv_byte(rb); close_x();
    check("R10 underrun byte", {24'd0, rb}, 32'hFF);

    // R6: release after 5 opcode bits
    e0 = n_exec; r0 = n_rej;
    open_x(); for (int i = 0; i < 5; i++) pulse_bit(1'b0); close_x();
    check("R6 short opcode ignored", (n_exec - e0) + (n_rej - r0), 32'd0);
    check("R6 latch unchanged", {31'd0, wel}, 32'd0);

    // R12: next transaction starts clean
    open_x(); send_byte(8'h06); close_x();
    check("R12 clean start after abort", {24'd0, last_op}, 32'h06);
    // R12: abort mid-address of a read, then chip erase
    e0 = n_exec;
    open_x(); send_byte(8'h03); send_byte(8'h77); for (int i = 0; i < 4; i++) pulse_bit(1'b1); close_x();
    open_x(); send_byte(8'hC7); close_x();
    check("R12 erase after aborted read", n_exec - e0, 32'd1);
    check("R12 erase opcode", {24'd0, last_op}, 32'hC7);

    done = 1'b1;
    finish_run();
  end
endmodule